// File: doc/BRIEF.md
# Write-once synchronising memory cell controller

This block is a memory element that answers tokens over a 16-bit address space. The lower half of the space is plain shared storage. It has no synchronisation: a write stores a word and a read returns whatever is held there. The upper half holds synchronised cells. Each cell carries a presence state next to its data word, so a consumer can read a value before its producer has written it. Such a read is not answered with stale data. The cell keeps the requester's return tag and answers it when the value arrives.

A request carries an operation code, an address, a 16-bit data word and a return tag (destination and context). All responses are tokens that go back to a return tag, one cycle after the request that caused them. Misuse of a synchronised cell does not produce a response: a second write to a filled cell and a second reader on a pending cell each raise a one-cycle error pulse with a code. The block takes one request per clock and applies no backpressure.

Top module: `ismem_ctrl`

## Requirements
- R1: After reset, every synchronised cell is empty and both rsp_valid and err_valid are low.
- R2: An address with bit 15 clear selects plain storage (low 8 bits index it by default). A write (op 1) stores the word with no response, and a read (op 0) returns the stored word to the request's tag. Reserve (op 2) and clear (op 3) on this region have no effect.
- R3: A read (op 0) of a full cell (bit 15 set, low 6 bits index the cell by default) returns the cell's data to the request's destination and context, every time it is read.
- R4: A read of an empty or reserved cell produces no response. The cell parks the request's tag and enters the waiting state.
- R5: A write to a waiting cell stores the data, makes the cell full, and sends the written data to the parked destination and context.
- R6: A write to a full cell raises err_valid with err_code 1, produces no response, and leaves the stored data unchanged.
- R7: A read of a waiting cell raises err_valid with err_code 2 and produces no response. The reader parked first stays parked and is the one answered later.
- R8: A reserve moves an empty cell to reserved. On a full or waiting cell it has no effect.
- R9: A clear returns any cell to empty and drops a parked reader, so the next write to that cell produces no response.
- R10: A write to an empty or reserved cell makes it full without producing a response.
- R11: Each response or error appears exactly one clock after the request that caused it, and rsp_valid and err_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 reserve, 3 clear |
| req_addr | input | 16 | Word address; bit 15 selects the synchronised region |
| req_data | input | 16 | Write data |
| req_dest | input | 8 | Return destination of the requester |
| req_ctx | input | 4 | Return context of the requester |
| rsp_valid | output | 1 | A response token is present |
| rsp_data | output | 16 | Response data |
| rsp_dest | output | 8 | Destination the response is addressed to |
| rsp_ctx | output | 4 | Context the response is addressed to |
| err_valid | output | 1 | Error pulse |
| err_code | output | 2 | 1 second write to a full cell, 2 extra reader on a waiting cell |

## Verification
The assertions check invariants that hold on every cycle. The data word of a full cell is never written. A cell only becomes full through a data write, and it only becomes waiting when a tag is parked. A response and an error never share a cycle, and no response appears without a request in the cycle before. Some behaviour can only be shown by the bench's scenarios, each as a sequence of tokens: which tag a deferred write answers, that the first reader survives an extra read, that a clear drops a parked reader, and that reserve and clear leave plain storage alone.

// File: rtl/ismem_pkg.sv
package ismem_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_RESERVE = 2'd2,
        OP_CLEAR   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CS_EMPTY = 2'd0,
        CS_RESV  = 2'd1,
        CS_FULL  = 2'd2,
        CS_WAIT  = 2'd3
    } cell_e;

    localparam logic [1:0] ERR_NONE         = 2'd0;
    localparam logic [1:0] ERR_DUP_WRITE    = 2'd1;
    localparam logic [1:0] ERR_EXTRA_READER = 2'd2;

endpackage

// File: rtl/ismem_raw_bank.sv
module ismem_raw_bank #(
    parameter int WORDS  = 256,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];

    assign rdata = mem_q[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end

endmodule

// File: rtl/ismem_cell_bank.sv
module ismem_cell_bank
    import ismem_pkg::*;
#(
    parameter int CELLS  = 64,
    parameter int DATA_W = 16,
    parameter int DEST_W = 8,
    parameter int CTX_W  = 4,
    parameter int IDX_W  = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output cell_e             rd_state,
    output logic [DATA_W-1:0] rd_data,
    output logic [DEST_W-1:0] rd_dest,
    output logic [CTX_W-1:0]  rd_ctx,
    input  logic              state_we,
    input  cell_e             wstate,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              park_we,
    input  logic [DEST_W-1:0] pdest,
    input  logic [CTX_W-1:0]  pctx
);

    cell_e             state_q [CELLS];
    logic [DATA_W-1:0] data_q  [CELLS];
    logic [DEST_W-1:0] dest_q  [CELLS];
    logic [CTX_W-1:0]  ctx_q   [CELLS];

    assign rd_state = state_q[idx];
    assign rd_data  = data_q[idx];
    assign rd_dest  = dest_q[idx];
    assign rd_ctx   = ctx_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CELLS; i++) begin
                state_q[i] <= CS_EMPTY;
            end
        end else if (state_we) begin
            state_q[idx] <= wstate;
        end
    end

    always_ff @(posedge clk) begin
        if (data_we) begin
            data_q[idx] <= wdata;
        end
        if (park_we) begin
            dest_q[idx] <= pdest;
            ctx_q[idx]  <= pctx;
        end
    end

    // R6
    no_full_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        data_we |-> (rd_state != CS_FULL));

    // R10
    full_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state_we && wstate == CS_FULL) |-> data_we);

    // R4
    wait_needs_park_chk: assert property (@(posedge clk) disable iff (rst)
        (state_we && wstate == CS_WAIT) |-> park_we);

endmodule

// File: rtl/ismem_ctrl.sv
module ismem_ctrl
    import ismem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int DEST_W    = 8,
    parameter int CTX_W     = 4,
    parameter int CELLS     = 64,
    parameter int RAW_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DEST_W-1:0] req_dest,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DEST_W-1:0] rsp_dest,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic              err_valid,
    output logic [1:0]        err_code
);

    localparam int CELL_AW = $clog2(CELLS);
    localparam int RAW_AW  = $clog2(RAW_WORDS);

    typedef struct packed {
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic [DEST_W-1:0] rsp_dst;
        logic [CTX_W-1:0]  rsp_ctx;
        logic              err_v;
        logic [1:0]        err_c;
    } out_t;

    out_t st_d, st_q;

    // address decode
    logic               in_sync;
    logic [CELL_AW-1:0] cell_idx;
    logic [RAW_AW-1:0]  raw_idx;
    logic               addr_unused;
    op_e                op;

    assign in_sync     = req_addr[ADDR_W-1];
    assign cell_idx    = req_addr[CELL_AW-1:0];
    assign raw_idx     = req_addr[RAW_AW-1:0];
    assign addr_unused = ^req_addr;
    assign op          = op_e'(req_op);

    // storage ports
    cell_e             cur_state;
    logic [DATA_W-1:0] cur_data;
    logic [DEST_W-1:0] cur_dest;
    logic [CTX_W-1:0]  cur_ctx;
    logic              state_we, data_we, park_we, raw_we;
    cell_e             next_state;
    logic [DATA_W-1:0] raw_rdata;

    ismem_cell_bank #(
        .CELLS  (CELLS),
        .DATA_W (DATA_W),
        .DEST_W (DEST_W),
        .CTX_W  (CTX_W),
        .IDX_W  (CELL_AW)
    ) u_cells (
        .clk      (clk),
        .rst      (rst),
        .idx      (cell_idx),
        .rd_state (cur_state),
        .rd_data  (cur_data),
        .rd_dest  (cur_dest),
        .rd_ctx   (cur_ctx),
        .state_we (state_we),
        .wstate   (next_state),
        .data_we  (data_we),
        .wdata    (req_data),
        .park_we  (park_we),
        .pdest    (req_dest),
        .pctx     (req_ctx)
    );

    ismem_raw_bank #(
        .WORDS  (RAW_WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (RAW_AW)
    ) u_raw (
        .clk   (clk),
        .idx   (raw_idx),
        .we    (raw_we),
        .wdata (req_data),
        .rdata (raw_rdata)
    );

    always_comb begin
        st_d       = '0;
        state_we   = 1'b0;
        data_we    = 1'b0;
        park_we    = 1'b0;
        raw_we     = 1'b0;
        next_state = cur_state;

        if (req_valid && !in_sync) begin
            if (op == OP_READ) begin
                st_d.rsp_v   = 1'b1;
                st_d.rsp_d   = raw_rdata;
                st_d.rsp_dst = req_dest;
                st_d.rsp_ctx = req_ctx;
            end else if (op == OP_WRITE) begin
                raw_we = 1'b1;
            end
        end else if (req_valid) begin
            unique case (op)
                OP_READ: begin
                    if (cur_state == CS_FULL) begin
                        st_d.rsp_v   = 1'b1;
                        st_d.rsp_d   = cur_data;
                        st_d.rsp_dst = req_dest;
                        st_d.rsp_ctx = req_ctx;
                    end else if (cur_state == CS_WAIT) begin
                        st_d.err_v = 1'b1;
                        st_d.err_c = ERR_EXTRA_READER;
                    end else begin
                        state_we   = 1'b1;
                        next_state = CS_WAIT;
                        park_we    = 1'b1;
                    end
                end
                OP_WRITE: begin
                    if (cur_state == CS_FULL) begin
                        st_d.err_v = 1'b1;
                        st_d.err_c = ERR_DUP_WRITE;
                    end else begin
                        state_we   = 1'b1;
                        next_state = CS_FULL;
                        data_we    = 1'b1;
                        if (cur_state == CS_WAIT) begin
                            st_d.rsp_v   = 1'b1;
                            st_d.rsp_d   = req_data;
                            st_d.rsp_dst = cur_dest;
                            st_d.rsp_ctx = cur_ctx;
                        end
                    end
                end
                OP_RESERVE: begin
                    if (cur_state == CS_EMPTY) begin
                        state_we   = 1'b1;
                        next_state = CS_RESV;
                    end
                end
                OP_CLEAR: begin
                    state_we   = 1'b1;
                    next_state = CS_EMPTY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_data  = st_q.rsp_d;
    assign rsp_dest  = st_q.rsp_dst;
    assign rsp_ctx   = st_q.rsp_ctx;
    assign err_valid = st_q.err_v;
    assign err_code  = st_q.err_c;

    // R11
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || err_valid) |-> $past(req_valid));

    // R11
    rsp_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_valid, err_valid}));

    // R6
    err_code_known_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code == ERR_DUP_WRITE || err_code == ERR_EXTRA_READER));

endmodule

// File: tb/ismem_ctrl_bench.sv
`timescale 1ns/100ps
module ismem_ctrl_bench;

    typedef struct packed {
        logic        v;
        logic [15:0] d;
        logic [7:0]  dst;
        logic [3:0]  ctx;
        logic        ev;
        logic [1:0]  ec;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [7:0]  req_dest = '0;
    logic [3:0]  req_ctx = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [7:0]  rsp_dest;
    logic [3:0]  rsp_ctx;
    logic        err_valid;
    logic [1:0]  err_code;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    exp_t  exp_q [$];
    string tag_q [$];

    always #2.5 clk = ~clk;

    ismem_ctrl u_ismem_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_dest  (req_dest),
        .req_ctx   (req_ctx),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_dest  (rsp_dest),
        .rsp_ctx   (rsp_ctx),
        .err_valid (err_valid),
        .err_code  (err_code)
    );

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, RS = 2'd2, CL = 2'd3;

    function automatic exp_t nothing();
        return '0;
    endfunction

    function automatic exp_t answer(logic [15:0] d, logic [7:0] dst, logic [3:0] ctx);
        exp_t e = '0;
        e.v = 1'b1; e.d = d; e.dst = dst; e.ctx = ctx;
        return e;
    endfunction

    function automatic exp_t fault(logic [1:0] c);
        exp_t e = '0;
        e.ev = 1'b1; e.ec = c;
        return e;
    endfunction

    function automatic logic [15:0] sc(int i);
        return 16'h8000 | 16'(i);
    endfunction

    // driver: one request per call, expected outcome queued for the monitor
    task automatic issue(input logic [1:0] op, input logic [15:0] addr,
                         input logic [15:0] data, input logic [7:0] dst,
                         input logic [3:0] ctx, input exp_t e, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_data  = data;
        req_dest  = dst;
        req_ctx   = ctx;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        exp_q.push_back(nothing());
        tag_q.push_back(tag);
    endtask

    // monitor: compares each registered outcome one clock after its request
    always @(posedge clk) begin
        #1;
        if (mon_en && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            bit    bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            bad = (rsp_valid !== e.v) || (err_valid !== e.ev);
            if (e.ev && err_code !== e.ec) bad = 1'b1;
            if (e.v && (rsp_data !== e.d || rsp_dest !== e.dst || rsp_ctx !== e.ctx)) bad = 1'b1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got v=%0b d=%h dst=%h ctx=%h ev=%0b ec=%0d exp v=%0b d=%h dst=%h ctx=%h ev=%0b ec=%0d",
                         t, rsp_valid, rsp_data, rsp_dest, rsp_ctx, err_valid, err_code,
                         e.v, e.d, e.dst, e.ctx, e.ev, e.ec);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || err_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got rsp_valid=%0b err_valid=%0b exp 0 0", rsp_valid, err_valid);
        end
        mon_en = 1'b1;

        // plain storage region
        issue(WR, 16'h0012, 16'hBEEF, 8'h00, 4'h0, nothing(), "R2 raw write silent");
        issue(RD, 16'h0012, 16'h0000, 8'h11, 4'h2, answer(16'hBEEF, 8'h11, 4'h2), "R2 raw read");
        issue(RS, 16'h0012, 16'h0000, 8'h00, 4'h0, nothing(), "R2 raw reserve");
        issue(CL, 16'h0012, 16'h0000, 8'h00, 4'h0, nothing(), "R2 raw clear");
        issue(RD, 16'h0012, 16'h0000, 8'h12, 4'h5, answer(16'hBEEF, 8'h12, 4'h5), "R2 raw unaffected");

        // fill, read, duplicate write
        issue(WR, sc(5), 16'h1234, 8'h00, 4'h0, nothing(), "R10 write empty");
        issue(RD, sc(5), 16'h0000, 8'h21, 4'h1, answer(16'h1234, 8'h21, 4'h1), "R3 read full");
        issue(RD, sc(5), 16'h0000, 8'h22, 4'h6, answer(16'h1234, 8'h22, 4'h6), "R3 reread full");
        issue(WR, sc(5), 16'h9999, 8'h00, 4'h0, fault(2'd1), "R6 double write");
        issue(RD, sc(5), 16'h0000, 8'h23, 4'h7, answer(16'h1234, 8'h23, 4'h7), "R6 data kept");

        // deferred read, extra reader, fulfilment
        issue(RD, sc(7), 16'h0000, 8'h31, 4'h3, nothing(), "R4 R1 read empty parks");
        issue(RD, sc(7), 16'h0000, 8'h32, 4'h9, fault(2'd2), "R7 extra reader");
        issue(WR, sc(7), 16'h5555, 8'h00, 4'h0, answer(16'h5555, 8'h31, 4'h3), "R5 R7 deferred answer");
        issue(RD, sc(7), 16'h0000, 8'h33, 4'h4, answer(16'h5555, 8'h33, 4'h4), "R5 now full");

        // reserve paths
        issue(RS, sc(9), 16'h0000, 8'h00, 4'h0, nothing(), "R8 reserve empty");
        issue(RD, sc(9), 16'h0000, 8'h41, 4'h4, nothing(), "R4 read reserved parks");
        issue(WR, sc(9), 16'h7777, 8'h00, 4'h0, answer(16'h7777, 8'h41, 4'h4), "R8 reserved then answered");
        issue(RS, sc(5), 16'h0000, 8'h00, 4'h0, nothing(), "R8 reserve full");
        issue(RD, sc(5), 16'h0000, 8'h24, 4'h8, answer(16'h1234, 8'h24, 4'h8), "R8 full unaffected");
        issue(RD, sc(20), 16'h0000, 8'h71, 4'hA, nothing(), "R4 park for reserve");
        issue(RS, sc(20), 16'h0000, 8'h00, 4'h0, nothing(), "R8 reserve waiting");
        issue(WR, sc(20), 16'h2222, 8'h00, 4'h0, answer(16'h2222, 8'h71, 4'hA), "R8 waiting kept");

        // clear paths
        issue(RD, sc(11), 16'h0000, 8'h51, 4'h5, nothing(), "R4 park for clear");
        issue(CL, sc(11), 16'h0000, 8'h00, 4'h0, nothing(), "R9 clear waiting");
        issue(WR, sc(11), 16'hAAAA, 8'h00, 4'h0, nothing(), "R9 parked reader dropped");
        issue(RD, sc(11), 16'h0000, 8'h52, 4'h6, answer(16'hAAAA, 8'h52, 4'h6), "R10 full after write");
        issue(CL, sc(5), 16'h0000, 8'h00, 4'h0, nothing(), "R9 clear full");
        issue(RD, sc(5), 16'h0000, 8'h61, 4'hB, nothing(), "R9 cleared cell parks");
        issue(WR, sc(5), 16'h0F0F, 8'h00, 4'h0, answer(16'h0F0F, 8'h61, 4'hB), "R9 refill answers");

        // reserved then written, back-to-back with idle gaps
        issue(RS, sc(13), 16'h0000, 8'h00, 4'h0, nothing(), "R8 reserve");
        issue(WR, sc(13), 16'h1111, 8'h00, 4'h0, nothing(), "R10 write reserved");
        idle("R11 idle gap");
        issue(RD, sc(13), 16'h0000, 8'h81, 4'hC, answer(16'h1111, 8'h81, 4'hC), "R10 reserved filled");
        idle("R11 no late response");
        idle("R11 quiet");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule